// File: doc/BRIEF.md
# Adapter Interruption Suppression Filter

This block sits in front of an I/O interruption queue. It filters adapter interruptions by interruption subclass before they are queued. For each of the eight subclasses it holds two bits. The one-shot bit arms single-interruption behaviour. The blocked bit drops suppressible events. Software programs these bits through a mode-write port, which takes a subclass and a mode code. An unknown mode code is reported as an error.

Devices raise adapter events on an inject port, which takes a subclass and a suppressible flag. An event is either dropped or turned into an I/O inject request for the queue. The request carries a formed interruption word, and its subchannel identifier, subchannel number and parameter are all zero. In one-shot mode the first suppressible event for a subclass is delivered. That delivery sets the blocked bit, so later suppressible events are dropped until software writes a mode for the subclass again. Events that are not suppressible always pass.

Top module: `ais_filter`

## Requirements
- R1: A mode write with code 0 (deliver all) clears both the one-shot bit and the blocked bit of its subclass one cycle later.
- R2: A mode write with code 1 (one-shot) sets the one-shot bit and clears the blocked bit of its subclass one cycle later.
- R3: A mode write with any code other than 0 or 1 raises `modeErr` for exactly the following cycle and leaves both masks unchanged.
- R4: A suppressible inject whose subclass has its blocked bit set produces no request. `ioReqValid` stays low in the next cycle.
- R5: When a suppressible inject is forwarded and its subclass has the one-shot bit set, the blocked bit of that subclass is set one cycle later. Further suppressible injects for that subclass are then dropped until a mode write re-arms it.
- R6: A non-suppressible inject is always forwarded one cycle later and changes neither mask.
- R7: A forwarded inject drives `ioReqValid` high for one cycle, starting one cycle after the inject. The word has bit 31 set, the subclass in bits 29:27, and every other bit zero. `ioReqSchId`, `ioReqSchNr` and `ioReqParm` are zero.
- R8: Subclass s maps to bit 7-s of both `oneShotMask` and `blockedMask`, so subclass 0 is the most significant bit.
- R9: If a mode write and an inject for the same subclass arrive in the same cycle, the mode write is applied first. The inject is then judged, and may set the blocked bit, against the newly written bits.
- R10: While `rstN` is low both masks are zero and `ioReqValid` and `modeErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeValid | input | 1 | Mode write strobe |
| modeSub | input | 3 | Subclass targeted by the mode write |
| modeCode | input | 16 | Mode code: 0 deliver all, 1 one-shot |
| injValid | input | 1 | Adapter event strobe |
| injSub | input | 3 | Subclass of the adapter event |
| injSupp | input | 1 | Event may be suppressed |
| ioReqValid | output | 1 | I/O inject request to the queue |
| ioReqWord | output | 32 | Formed interruption word |
| ioReqSchId | output | 16 | Subchannel identifier (always zero) |
| ioReqSchNr | output | 16 | Subchannel number (always zero) |
| ioReqParm | output | 32 | Interruption parameter (always zero) |
| modeErr | output | 1 | Invalid mode code reported |
| oneShotMask | output | 8 | One-shot bits, subclass 0 at bit 7 |
| blockedMask | output | 8 | Blocked bits, subclass 0 at bit 7 |

## Verification
The assertions check on every cycle the following behaviours:
- the one-cycle effect of each mode code on its subclass bits;
- that an error pulse follows an unknown code and that the masks stay put;
- that blocked suppressible events are dropped;
- that non-suppressible events always pass;
- the layout of every request word.

Some behaviours appear only across a sequence, and only the bench scenarios can show them:
- the full one-shot cycle of deliver, block and re-arm;
- the ordering when a mode write and an inject for the same subclass collide;
- the MSB-first mapping of subclass to mask bit;
- clearing by a mid-run reset.

// File: rtl/ais_pkg.sv
package ais_pkg;
  localparam int SUB_CNT = 8;
  localparam int SUB_W   = $clog2(SUB_CNT);

  typedef struct packed {
    logic [SUB_CNT-1:0] setOneShot;
    logic [SUB_CNT-1:0] clrOneShot;
    logic [SUB_CNT-1:0] setBlocked;
    logic [SUB_CNT-1:0] clrBlocked;
    logic               fwd;
    logic [SUB_W-1:0]   fwdSub;
    logic               err;
  } maskStrobes_t;
endpackage

// File: rtl/ais_ctrl.sv
module ais_ctrl
  import ais_pkg::*;
#(
  parameter int CODE_W      = 16,
  parameter int CODE_ALL    = 0,
  parameter int CODE_SINGLE = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeValid,
  input  logic [SUB_W-1:0]   modeSub,
  input  logic [CODE_W-1:0]  modeCode,
  input  logic               injValid,
  input  logic [SUB_W-1:0]   injSub,
  input  logic               injSupp,
  input  logic [SUB_CNT-1:0] oneShotQ,
  input  logic [SUB_CNT-1:0] blockedQ,
  output maskStrobes_t       strb
);
  function automatic logic [SUB_CNT-1:0] subBit(input logic [SUB_W-1:0] s);
    logic [SUB_CNT-1:0] b;
    b = '0;
    b[SUB_CNT-1-int'(s)] = 1'b1;
    return b;
  endfunction

  logic isAll, isSingle, modeOk, sameSub;
  logic [SUB_CNT-1:0] modeBit, injBit;
  logic effOneShot, effBlocked;

  assign isAll    = (modeCode == CODE_W'(CODE_ALL));
  assign isSingle = (modeCode == CODE_W'(CODE_SINGLE));
  assign modeOk   = modeValid && (isAll || isSingle);
  assign modeBit  = subBit(modeSub);
  assign injBit   = subBit(injSub);
  assign sameSub  = modeOk && (modeSub == injSub);

  // The mode write is applied first when it targets the same subclass.
  assign effOneShot = sameSub ? isSingle : |(oneShotQ & injBit);
  assign effBlocked = sameSub ? 1'b0     : |(blockedQ & injBit);

  always_comb begin
    strb            = '0;
    strb.err        = modeValid && !modeOk;
    strb.clrOneShot = (modeOk && isAll)    ? modeBit : '0;
    strb.setOneShot = (modeOk && isSingle) ? modeBit : '0;
    strb.clrBlocked = modeOk ? modeBit : '0;
    strb.fwd        = injValid && !(injSupp && effBlocked);
    strb.fwdSub     = injSub;
    strb.setBlocked = (strb.fwd && injSupp && effOneShot) ? injBit : '0;
  end

  assert_mode_all_R1: assert property (@(posedge clk) disable iff (!rstN)
    (modeValid && isAll) |=>
      (!oneShotQ[SUB_CNT-1-int'($past(modeSub))] && !blockedQ[SUB_CNT-1-int'($past(modeSub))]));

  assert_mode_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeValid && isSingle && !(injValid && injSupp && injSub == modeSub)) |=>
      (oneShotQ[SUB_CNT-1-int'($past(modeSub))] && !blockedQ[SUB_CNT-1-int'($past(modeSub))]));

  assert_bad_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeValid && !isAll && !isSingle && !injValid) |=> ($stable(oneShotQ) && $stable(blockedQ)));
endmodule

// File: rtl/ais_datapath.sv
module ais_datapath
  import ais_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int SUB_SHIFT = 27,
  parameter int IND_BIT   = 31,
  parameter int ID_W      = 16,
  parameter int PARM_W    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  maskStrobes_t       strb,
  output logic [SUB_CNT-1:0] oneShotQ,
  output logic [SUB_CNT-1:0] blockedQ,
  output logic               reqValid,
  output logic [WORD_W-1:0]  reqWord,
  output logic [ID_W-1:0]    reqSchId,
  output logic [ID_W-1:0]    reqSchNr,
  output logic [PARM_W-1:0]  reqParm,
  output logic               errQ
);
  localparam logic [WORD_W-1:0] IND_MASK = WORD_W'(1) << IND_BIT;
  localparam logic [WORD_W-1:0] SUB_MASK = WORD_W'((1 << SUB_W) - 1) << SUB_SHIFT;

  logic [WORD_W-1:0] wordNext;

  always_comb begin
    wordNext = IND_MASK;
    wordNext[SUB_SHIFT +: SUB_W] = strb.fwdSub;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oneShotQ <= '0;
      blockedQ <= '0;
      reqValid <= 1'b0;
      reqWord  <= '0;
      errQ     <= 1'b0;
    end else begin
      oneShotQ <= (oneShotQ & ~strb.clrOneShot) | strb.setOneShot;
      blockedQ <= (blockedQ & ~strb.clrBlocked) | strb.setBlocked;
      reqValid <= strb.fwd;
      errQ     <= strb.err;
      if (strb.fwd) reqWord <= wordNext;
    end
  end

  assign reqSchId = '0;
  assign reqSchNr = '0;
  assign reqParm  = '0;

  assert_word_format_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqWord[IND_BIT] && ((reqWord & ~(IND_MASK | SUB_MASK)) == '0)));
endmodule

// File: rtl/ais_filter.sv
module ais_filter
  import ais_pkg::*;
#(
  parameter int CODE_W      = 16,
  parameter int CODE_ALL    = 0,
  parameter int CODE_SINGLE = 1,
  parameter int WORD_W      = 32,
  parameter int SUB_SHIFT   = 27,
  parameter int IND_BIT     = 31,
  parameter int ID_W        = 16,
  parameter int PARM_W      = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeValid,
  input  logic [SUB_W-1:0]   modeSub,
  input  logic [CODE_W-1:0]  modeCode,
  input  logic               injValid,
  input  logic [SUB_W-1:0]   injSub,
  input  logic               injSupp,
  output logic               ioReqValid,
  output logic [WORD_W-1:0]  ioReqWord,
  output logic [ID_W-1:0]    ioReqSchId,
  output logic [ID_W-1:0]    ioReqSchNr,
  output logic [PARM_W-1:0]  ioReqParm,
  output logic               modeErr,
  output logic [SUB_CNT-1:0] oneShotMask,
  output logic [SUB_CNT-1:0] blockedMask
);
  maskStrobes_t strb;

  ais_ctrl #(.CODE_W(CODE_W), .CODE_ALL(CODE_ALL), .CODE_SINGLE(CODE_SINGLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeValid(modeValid), .modeSub(modeSub), .modeCode(modeCode),
    .injValid(injValid), .injSub(injSub), .injSupp(injSupp),
    .oneShotQ(oneShotMask), .blockedQ(blockedMask), .strb(strb));

  ais_datapath #(.WORD_W(WORD_W), .SUB_SHIFT(SUB_SHIFT), .IND_BIT(IND_BIT),
                 .ID_W(ID_W), .PARM_W(PARM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .oneShotQ(oneShotMask), .blockedQ(blockedMask),
    .reqValid(ioReqValid), .reqWord(ioReqWord), .reqSchId(ioReqSchId),
    .reqSchNr(ioReqSchNr), .reqParm(ioReqParm), .errQ(modeErr));

  assert_drop_blocked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (injValid && injSupp && blockedMask[SUB_CNT-1-int'(injSub)] &&
     !(modeValid && modeSub == injSub)) |=> !ioReqValid);

  assert_one_shot_arm_R5: assert property (@(posedge clk) disable iff (!rstN)
    (injValid && injSupp && !modeValid && oneShotMask[SUB_CNT-1-int'(injSub)] &&
     !blockedMask[SUB_CNT-1-int'(injSub)]) |=>
      (ioReqValid && blockedMask[SUB_CNT-1-int'($past(injSub))]));

  assert_plain_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    (injValid && !injSupp && !modeValid) |=>
      (ioReqValid && $stable(oneShotMask) && $stable(blockedMask)));

  assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    !modeValid |=> !modeErr);
endmodule

// File: tb/sim_ais_filter.sv
`timescale 1ns/1ps
module sim_ais_filter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeValid = 1'b0, injValid = 1'b0, injSupp = 1'b0;
  logic [2:0] modeSub = '0, injSub = '0;
  logic [15:0] modeCode = '0;
  logic ioReqValid, modeErr;
  logic [31:0] ioReqWord, ioReqParm;
  logic [15:0] ioReqSchId, ioReqSchNr;
  logic [7:0] oneShotMask, blockedMask;

  int checks = 0, fails = 0;
  logic [7:0] mOne = '0, mBlk = '0;

  always #10 clk = ~clk;

  ais_filter u0 (.clk(clk), .rstN(rstN), .modeValid(modeValid), .modeSub(modeSub),
    .modeCode(modeCode), .injValid(injValid), .injSub(injSub), .injSupp(injSupp),
    .ioReqValid(ioReqValid), .ioReqWord(ioReqWord), .ioReqSchId(ioReqSchId),
    .ioReqSchNr(ioReqSchNr), .ioReqParm(ioReqParm), .modeErr(modeErr),
    .oneShotMask(oneShotMask), .blockedMask(blockedMask));

  function automatic logic [31:0] expWord(input logic [2:0] s);
    return 32'h8000_0000 | (32'(s) << 27);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic mv, input logic [2:0] ms, input logic [15:0] mc,
                      input logic iv, input logic [2:0] is, input logic sp);
    logic eErr, eVal;
    int mb, ib;
    @(negedge clk);
    modeValid = mv; modeSub = ms; modeCode = mc;
    injValid = iv; injSub = is; injSupp = sp;
    eErr = 1'b0; eVal = 1'b0;
    mb = 7 - int'(ms); ib = 7 - int'(is);
    if (mv) begin
      if (mc == 16'd0) begin mOne[mb] = 1'b0; mBlk[mb] = 1'b0; end
      else if (mc == 16'd1) begin mOne[mb] = 1'b1; mBlk[mb] = 1'b0; end
      else eErr = 1'b1;
    end
    if (iv && !(sp && mBlk[ib])) begin
      eVal = 1'b1;
      if (sp && mOne[ib]) mBlk[ib] = 1'b1;
    end
    @(posedge clk); #1;
    chk(tag, "valid", 32'(ioReqValid), 32'(eVal));
    chk(tag, "err", 32'(modeErr), 32'(eErr));
    chk(tag, "oneShot", 32'(oneShotMask), 32'(mOne));
    chk(tag, "blocked", 32'(blockedMask), 32'(mBlk));
    if (eVal) begin
      chk(tag, "word", ioReqWord, expWord(is));
      chk(tag, "zeros", {ioReqSchId, ioReqSchNr} | ioReqParm, 32'd0);
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 3'd0, 16'd0, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic doReset;
    @(negedge clk);
    rstN = 1'b0; modeValid = 1'b0; injValid = 1'b0;
    mOne = '0; mBlk = '0;
    @(posedge clk); #1;
    chk("R10", "rstValid", 32'(ioReqValid), 32'd0);
    chk("R10", "rstErr", 32'(modeErr), 32'd0);
    chk("R10", "rstMasks", {oneShotMask, blockedMask}, 32'd0);
    @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    doReset();
    idle("R10");
    // R8: subclass 0 at MSB, subclass 5 at bit 2
    step("R8", 1'b1, 3'd0, 16'd1, 1'b0, 3'd0, 1'b0);
    chk("R8", "msb", 32'(oneShotMask), 32'h80);
    step("R8", 1'b1, 3'd5, 16'd1, 1'b0, 3'd0, 1'b0);
    chk("R8", "bit2", 32'(oneShotMask), 32'h84);
    // R5 / R7: first suppressible delivered, then blocked
    step("R5", 1'b0, 3'd0, 16'd0, 1'b1, 3'd0, 1'b1);
    chk("R7", "word0", ioReqWord, 32'h8000_0000);
    chk("R5", "armed", 32'(blockedMask), 32'h80);
    step("R4", 1'b0, 3'd0, 16'd0, 1'b1, 3'd0, 1'b1);
    chk("R4", "dropped", 32'(ioReqValid), 32'd0);
    step("R6", 1'b0, 3'd0, 16'd0, 1'b1, 3'd0, 1'b0);
    chk("R6", "passes", 32'(ioReqValid), 32'd1);
    step("R7", 1'b0, 3'd0, 16'd0, 1'b1, 3'd7, 1'b0);
    chk("R7", "word7", ioReqWord, 32'hB800_0000);
    // R3: bad code leaves masks alone
    step("R3", 1'b1, 3'd0, 16'd7, 1'b0, 3'd0, 1'b0);
    chk("R3", "errPulse", 32'(modeErr), 32'd1);
    idle("R3");
    chk("R3", "errGone", 32'(modeErr), 32'd0);
    // R9: collide a deliver-all write with a suppressible inject on a blocked subclass
    step("R9", 1'b1, 3'd0, 16'd0, 1'b1, 3'd0, 1'b1);
    chk("R9", "fwdAfterAll", 32'(ioReqValid), 32'd1);
    chk("R1", "cleared", 32'(blockedMask & 8'h80), 32'd0);
    step("R9", 1'b0, 3'd2, 16'd0, 1'b1, 3'd2, 1'b1);
    step("R9", 1'b1, 3'd2, 16'd1, 1'b1, 3'd2, 1'b1);
    chk("R9", "rearmFwd", 32'(ioReqValid), 32'd1);
    chk("R9", "reblock", 32'(blockedMask & 8'h20), 32'h20);
    step("R2", 1'b1, 3'd2, 16'd1, 1'b0, 3'd0, 1'b0);
    chk("R2", "unblocked", 32'(blockedMask & 8'h20), 32'd0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] code;
      int pick;
      pick = int'($urandom_range(0, 4));
      code = (pick < 2) ? 16'(pick) : ((pick == 2) ? 16'd1 : 16'($urandom_range(2, 65535)));
      step("R1 R2 R3 R4 R5 R6 R9 random", 1'($urandom_range(0, 3) == 0), 3'($urandom_range(0, 7)), code,
           1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 1'($urandom_range(0, 3) != 0));
    end
    // R10 mid-run reset
    doReset();
    idle("R10");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule